// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets a small 8-bit CPU read, program and erase its own on-chip flash through a set of special-function registers. Software does four things before it starts an operation. It sets an enable bit and a clock-range code in a control register. It picks an operation in a mode register. It loads a 16-bit byte address into two address registers, and for a program operation it loads a data byte. It then writes a two-byte unlock key to a trigger register. The controller goes busy, waits for a time that depends on the clock range, and then drives single-cycle strobes to a synchronous flash macro.

A byte read returns the flash byte into the data register. A byte program can only clear bits: it reads the old byte and writes back the old byte AND the data byte. A page erase sets all 512 bytes of the addressed page to FFh. The control register also carries a software-reset request bit, which gives a one-cycle request pulse, and a boot-select flag that tells the reset logic which region to start from.

The sequencer has six states. ST_IDLE moves to ST_WAIT on an accepted start. ST_WAIT moves to ST_ERASE when the timer expires for an erase, and to ST_READ for a read or a program. ST_READ moves to ST_LATCH. ST_LATCH moves to ST_WRITE for a program and to ST_IDLE for a read. ST_WRITE and ST_ERASE both return to ST_IDLE.

Top module: `isp_ctrl`

## Requirements
- R1: After reset, the registers at E7h, E5h, E2h, E3h and E4h all read 00h, and busy, swrst_req and boot_isp are all 0.
- R2: The control register at E7h reads back bit7 (enable), bit6 (boot select) and bits 2:0 (clock range), and reads 0 in bits 5:3. The mode register at E5h reads back bits 2:0 and reads 0 in bits 7:3.
- R3: An operation starts only when the trigger register at E6h receives 46h immediately followed by B9h. Any other byte written to E6h between them cancels the key.
- R4: A completed key starts nothing when the enable bit is 0, or when the mode field is not 001 (read), 010 (program) or 011 (erase).
- R5: busy rises in the cycle after the B9h write. It stays high for N+2 cycles on a read, N+3 on a program and N+1 on an erase, where N = WAIT_UNIT*(8 - clock range).
- R6: When a read finishes, the data register at E2h holds the flash byte at address {E3h,E4h}.
- R7: A program issues exactly one write strobe, to address {E3h,E4h}, carrying the old flash byte AND the data register.
- R8: An erase issues one erase strobe whose address has its low 9 bits at zero. Every byte of that 512-byte page becomes FFh.
- R9: While busy is high, writes to E2h, E3h, E4h and E6h have no effect.
- R10: Writing E7h with bit5 set gives swrst_req high for exactly the next cycle, with boot_isp equal to the bit6 written. Bit5 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Register write strobe |
| sfr_rdata | output | 8 | Register read data, combinational on sfr_addr |
| fl_addr | output | 16 | Flash byte address, or page base address during an erase |
| fl_rd | output | 1 | Flash read strobe; data is returned on the next cycle |
| fl_wr | output | 1 | Flash byte write strobe |
| fl_erase | output | 1 | Flash page erase strobe |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | An operation is in progress |
| swrst_req | output | 1 | One-cycle software reset request |
| boot_isp | output | 1 | Boot-select flag: 1 selects the ISP region, 0 the application region |

## Verification
Each result is due a fixed number of cycles after the clock edge that takes the B9h key byte. busy shows 1 on the first falling edge after that edge. It is still 1 after N+1 more falling edges on a read, N+2 on a program and N on an erase, and it is 0 exactly one falling edge later. The bench samples at those exact falling edges rather than waiting on a level. The read-data, readback and flash-content checks run only after busy is seen low.

The software reset pulse is checked on the first falling edge after the control write and again one cycle later. Flash write strobes are compared as they appear, against a queue of expected address and data pairs that the stimulus pushed.

// File: rtl/isp_pkg.sv
package isp_pkg;
    localparam logic [7:0] ADR_DATA = 8'hE2;
    localparam logic [7:0] ADR_AHI  = 8'hE3;
    localparam logic [7:0] ADR_ALO  = 8'hE4;
    localparam logic [7:0] ADR_MODE = 8'hE5;
    localparam logic [7:0] ADR_TRIG = 8'hE6;
    localparam logic [7:0] ADR_CTRL = 8'hE7;

    localparam logic [7:0] KEY_FIRST  = 8'h46;
    localparam logic [7:0] KEY_SECOND = 8'hB9;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_PROG  = 3'd2,
        OP_ERASE = 3'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_LATCH,
        ST_WRITE,
        ST_ERASE
    } state_e;
endpackage

// File: rtl/isp_regs.sv
module isp_regs
    import isp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    sfr_addr,
    input  logic [7:0]    sfr_wdata,
    input  logic          sfr_we,
    output logic [7:0]    sfr_rdata,
    input  logic          busy,
    input  logic          ld_en,
    input  logic [7:0]    ld_val,
    output logic [2:0]    cks,
    output op_e           op,
    output logic [AW-1:0] addr,
    output logic [7:0]    data,
    output logic          start,
    output logic          swrst_req,
    output logic          boot_isp
);
    logic       en_q, swbs_q, armed_q, swrst_q;
    logic [2:0] cks_q, mode_q;
    logic [7:0] ahi_q, alo_q, data_q;

    logic wr_ctrl, wr_mode, wr_data, wr_ahi, wr_alo, wr_trig;
    logic key_hit, op_ok;

    assign wr_ctrl = sfr_we && (sfr_addr == ADR_CTRL);
    assign wr_mode = sfr_we && (sfr_addr == ADR_MODE);
    assign wr_data = sfr_we && (sfr_addr == ADR_DATA) && !busy;
    assign wr_ahi  = sfr_we && (sfr_addr == ADR_AHI)  && !busy;
    assign wr_alo  = sfr_we && (sfr_addr == ADR_ALO)  && !busy;
    assign wr_trig = sfr_we && (sfr_addr == ADR_TRIG) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            swbs_q  <= 1'b0;
            cks_q   <= '0;
            mode_q  <= '0;
            ahi_q   <= '0;
            alo_q   <= '0;
            data_q  <= '0;
            armed_q <= 1'b0;
            swrst_q <= 1'b0;
        end else begin
            swrst_q <= wr_ctrl && sfr_wdata[5];
            if (wr_ctrl) begin
                en_q   <= sfr_wdata[7];
                swbs_q <= sfr_wdata[6];
                cks_q  <= sfr_wdata[2:0];
            end
            if (wr_mode) mode_q <= sfr_wdata[2:0];
            if (wr_ahi)  ahi_q  <= sfr_wdata;
            if (wr_alo)  alo_q  <= sfr_wdata;
            if (ld_en)
                data_q <= ld_val;
            else if (wr_data)
                data_q <= sfr_wdata;
            if (wr_trig) armed_q <= (sfr_wdata == KEY_FIRST);
        end
    end

    assign key_hit = wr_trig && armed_q && (sfr_wdata == KEY_SECOND);
    assign op_ok   = (mode_q == OP_READ) || (mode_q == OP_PROG) || (mode_q == OP_ERASE);
    assign start   = key_hit && en_q && op_ok;

    assign op        = op_e'(mode_q);
    assign cks       = cks_q;
    assign addr      = {ahi_q, alo_q};
    assign data      = data_q;
    assign swrst_req = swrst_q;
    assign boot_isp  = swbs_q;

    always_comb begin
        case (sfr_addr)
            ADR_CTRL: sfr_rdata = {en_q, swbs_q, 3'b000, cks_q};
            ADR_MODE: sfr_rdata = {5'b00000, mode_q};
            ADR_DATA: sfr_rdata = data_q;
            ADR_AHI:  sfr_rdata = ahi_q;
            ADR_ALO:  sfr_rdata = alo_q;
            default:  sfr_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/isp_timer.sv
module isp_timer #(
    parameter int WAIT_UNIT = 4,
    parameter int CNT_W     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       expired
);
    logic [CNT_W-1:0] cnt_q, span;

    // Faster clock ranges (smaller codes) need more cycles for the same pulse time.
    assign span = CNT_W'((4'd8 - {1'b0, cks}) * WAIT_UNIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= span - CNT_W'(1);
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/isp_seq.sv
module isp_seq
    import isp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int PAGE_BITS = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_e           op_in,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    data_in,
    input  logic [7:0]    fl_rdata,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic          tmr_run,
    output logic          busy,
    output logic [AW-1:0] fl_addr,
    output logic          fl_rd,
    output logic          fl_wr,
    output logic          fl_erase,
    output logic [7:0]    fl_wdata,
    output logic          ld_en,
    output logic [7:0]    ld_val
);
    state_e     state_q, state_d;
    op_e        op_q;
    logic [7:0] old_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            old_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) op_q  <= op_in;
            if (state_q == ST_LATCH)         old_q <= fl_rdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_WAIT;
            ST_WAIT:  if (tmr_expired) state_d = (op_q == OP_ERASE) ? ST_ERASE : ST_READ;
            ST_READ:  state_d = ST_LATCH;
            ST_LATCH: state_d = (op_q == OP_PROG) ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            ST_ERASE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        tmr_load = (state_q == ST_IDLE) && start;
        tmr_run  = (state_q == ST_WAIT);
        fl_rd    = (state_q == ST_READ);
        fl_wr    = (state_q == ST_WRITE);
        fl_erase = (state_q == ST_ERASE);
        fl_wdata = old_q & data_in;
        ld_en    = (state_q == ST_LATCH) && (op_q == OP_READ);
        ld_val   = fl_rdata;
        fl_addr  = (op_q == OP_ERASE) ? {addr_in[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}} : addr_in;
    end
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int WAIT_UNIT = 4,
    parameter int PAGE_BITS = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  sfr_addr,
    input  logic [7:0]  sfr_wdata,
    input  logic        sfr_we,
    output logic [7:0]  sfr_rdata,
    output logic [15:0] fl_addr,
    output logic        fl_rd,
    output logic        fl_wr,
    output logic        fl_erase,
    output logic [7:0]  fl_wdata,
    input  logic [7:0]  fl_rdata,
    output logic        busy,
    output logic        swrst_req,
    output logic        boot_isp
);
    localparam int AW    = 16;
    localparam int CNT_W = $clog2(8 * WAIT_UNIT + 1);

    logic [2:0]    cks;
    op_e           op;
    logic [AW-1:0] addr;
    logic [7:0]    data, ld_val;
    logic          start, ld_en, tmr_load, tmr_run, tmr_expired;

    isp_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we), .sfr_rdata(sfr_rdata),
        .busy(busy), .ld_en(ld_en), .ld_val(ld_val),
        .cks(cks), .op(op), .addr(addr), .data(data), .start(start),
        .swrst_req(swrst_req), .boot_isp(boot_isp)
    );

    isp_timer #(.WAIT_UNIT(WAIT_UNIT), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
        .cks(cks), .expired(tmr_expired)
    );

    isp_seq #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op),
        .addr_in(addr), .data_in(data), .fl_rdata(fl_rdata),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_run(tmr_run),
        .busy(busy), .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_wr(fl_wr),
        .fl_erase(fl_erase), .fl_wdata(fl_wdata), .ld_en(ld_en), .ld_val(ld_val)
    );
endmodule

// File: rtl/isp_ctrl_chk.sv
module isp_ctrl_chk #(
    parameter int PAGE_BITS = 9
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sfr_addr,
    input logic [7:0]  sfr_wdata,
    input logic        sfr_we,
    input logic [15:0] fl_addr,
    input logic        fl_rd,
    input logic        fl_wr,
    input logic        fl_erase,
    input logic        busy,
    input logic        swrst_req
);
    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_rd, fl_wr, fl_erase}));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(fl_rd || fl_wr || fl_erase));

    assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr |-> $past(fl_rd, 2));

    assert_erase_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_erase |-> (fl_addr[PAGE_BITS-1:0] == '0));

    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(fl_addr)));

    assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> !swrst_req);

    assert_reset_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |-> $past(sfr_we && sfr_addr == 8'hE7 && sfr_wdata[5]));
endmodule

bind isp_ctrl isp_ctrl_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_wr(fl_wr),
    .fl_erase(fl_erase), .busy(busy), .swrst_req(swrst_req)
);

// File: tb/isp_ctrl_tb.sv
`timescale 1ns/100ps
module isp_ctrl_tb;
    localparam int WAIT_UNIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_rdata;
    logic [15:0] fl_addr;
    logic        fl_rd, fl_wr, fl_erase;
    logic [7:0]  fl_wdata;
    logic [7:0]  fl_rdata = 8'h00;
    logic        busy, swrst_req, boot_isp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_item_t;
    wr_item_t exp_wr[$];

    logic [7:0] mem [0:4095];

    always #2.5 clk = ~clk;

    isp_ctrl #(.WAIT_UNIT(WAIT_UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .fl_addr(fl_addr), .fl_rd(fl_rd),
        .fl_wr(fl_wr), .fl_erase(fl_erase), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .busy(busy), .swrst_req(swrst_req), .boot_isp(boot_isp)
    );

    function automatic logic [7:0] seed(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    initial for (int i = 0; i < 4096; i++) mem[i] = seed(i);

    always @(posedge clk) begin
        if (fl_rd) fl_rdata <= mem[fl_addr[11:0]];
        if (fl_wr) mem[fl_addr[11:0]] <= fl_wdata;
        if (fl_erase)
            for (int i = 0; i < 512; i++) mem[{fl_addr[11:9], 9'(i)}] <= 8'hFF;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every flash write strobe must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && fl_wr) begin
            if (exp_wr.size() == 0) begin
                chk("R7 unexpected write", {16'h0, fl_addr}, 32'hFFFF_FFFF);
            end else begin
                wr_item_t it;
                it = exp_wr.pop_front();
                chk("R7 write addr", {16'h0, fl_addr}, {16'h0, it.a});
                chk("R7 write data", {24'h0, fl_wdata}, {24'h0, it.d});
            end
        end
    end

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a;
        #1 d = sfr_rdata;
    endtask

    task automatic unlock();
        sfr_write(8'hE6, 8'h46);
        sfr_write(8'hE6, 8'hB9);
    endtask

    // Called at the first falling edge after the key edge; checks the exact busy window.
    task automatic busy_window(input string tag, input int len);
        chk({tag, " busy rise"}, {31'h0, busy}, 1);
        repeat (len - 1) @(negedge clk);
        chk({tag, " busy last"}, {31'h0, busy}, 1);
        @(negedge clk);
        chk({tag, " busy end"}, {31'h0, busy}, 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sfr_read(8'hE7, rd); chk("R1 ctrl", {24'h0, rd}, 0);
        sfr_read(8'hE5, rd); chk("R1 mode", {24'h0, rd}, 0);
        sfr_read(8'hE2, rd); chk("R1 data", {24'h0, rd}, 0);
        sfr_read(8'hE3, rd); chk("R1 ahi", {24'h0, rd}, 0);
        sfr_read(8'hE4, rd); chk("R1 alo", {24'h0, rd}, 0);
        chk("R1 busy/swrst/boot", {29'h0, busy, swrst_req, boot_isp}, 0);

        // R2: readback masking
        sfr_write(8'hE7, 8'h9F);
        sfr_read(8'hE7, rd); chk("R2 ctrl", {24'h0, rd}, 32'h87);
        sfr_write(8'hE5, 8'hF9);
        sfr_read(8'hE5, rd); chk("R2 mode", {24'h0, rd}, 32'h01);

        // R5 / R6: read with clock range 7, N = 4
        sfr_write(8'hE3, 8'h01);
        sfr_write(8'hE4, 8'h23);
        unlock();
        busy_window("R5 read", WAIT_UNIT * 1 + 2);
        sfr_read(8'hE2, rd); chk("R6 read data", {24'h0, rd}, {24'h0, seed(16'h0123)});

        // R3: broken key does nothing, repeated first byte still arms
        sfr_write(8'hE6, 8'h46);
        sfr_write(8'hE6, 8'h00);
        sfr_write(8'hE6, 8'hB9);
        @(negedge clk); chk("R3 broken key", {31'h0, busy}, 0);
        sfr_write(8'hE6, 8'h46);
        sfr_write(8'hE6, 8'h46);
        sfr_write(8'hE6, 8'hB9);
        chk("R3 rearmed key", {31'h0, busy}, 1);
        wait_idle();

        // R4: disabled, standby mode, undefined mode
        sfr_write(8'hE7, 8'h07);
        unlock();
        chk("R4 disabled", {31'h0, busy}, 0);
        sfr_write(8'hE7, 8'h87);
        sfr_write(8'hE5, 8'h00);
        unlock();
        chk("R4 standby", {31'h0, busy}, 0);
        sfr_write(8'hE5, 8'h05);
        unlock();
        chk("R4 undefined mode", {31'h0, busy}, 0);

        // R7 / R5: program with clock range 3, N = 20; old 0Ch AND F5h = 04h
        sfr_write(8'hE7, 8'h83);
        sfr_write(8'hE5, 8'h02);
        sfr_write(8'hE3, 8'h04);
        sfr_write(8'hE4, 8'h56);
        sfr_write(8'hE2, 8'hF5);
        exp_wr.push_back('{a: 16'h0456, d: 8'h04});
        unlock();
        busy_window("R5 program", WAIT_UNIT * 5 + 3);
        chk("R7 queue drained", exp_wr.size(), 0);
        chk("R7 flash byte", {24'h0, mem[12'h456]}, 32'h04);

        // R8 / R5 / R9: erase with clock range 0, N = 32; register writes while busy
        sfr_write(8'hE7, 8'h80);
        sfr_write(8'hE5, 8'h03);
        sfr_write(8'hE3, 8'h0A);
        sfr_write(8'hE4, 8'h77);
        unlock();
        busy_window("R5 erase", WAIT_UNIT * 8 + 1);
        chk("R8 page first", {24'h0, mem[12'hA00]}, 32'hFF);
        chk("R8 page last", {24'h0, mem[12'hBFF]}, 32'hFF);
        chk("R8 below page", {24'h0, mem[12'h9FF]}, {24'h0, seed(12'h9FF)});
        chk("R8 above page", {24'h0, mem[12'hC00]}, {24'h0, seed(12'hC00)});

        unlock();
        chk("R9 busy for ignore test", {31'h0, busy}, 1);
        sfr_write(8'hE3, 8'h00);
        sfr_write(8'hE4, 8'h00);
        sfr_write(8'hE2, 8'hAA);
        sfr_write(8'hE6, 8'h46);
        wait_idle();
        sfr_read(8'hE3, rd); chk("R9 ahi held", {24'h0, rd}, 32'h0A);
        sfr_read(8'hE4, rd); chk("R9 alo held", {24'h0, rd}, 32'h77);
        sfr_read(8'hE2, rd); chk("R9 data held", {24'h0, rd}, 32'hF5);
        sfr_write(8'hE6, 8'hB9);
        chk("R9 key ignored", {31'h0, busy}, 0);

        // R6: read of erased page through the controller
        sfr_write(8'hE5, 8'h01);
        sfr_write(8'hE3, 8'h0B);
        sfr_write(8'hE4, 8'h10);
        unlock();
        wait_idle();
        sfr_read(8'hE2, rd); chk("R6 erased read", {24'h0, rd}, 32'hFF);

        // R10: software reset pulse and boot select
        sfr_write(8'hE7, 8'hE7);
        chk("R10 pulse isp", {30'h0, swrst_req, boot_isp}, 32'h3);
        @(negedge clk);
        chk("R10 pulse ends", {31'h0, swrst_req}, 0);
        sfr_read(8'hE7, rd); chk("R10 readback", {24'h0, rd}, 32'hC7);
        sfr_write(8'hE7, 8'hA7);
        chk("R10 pulse app", {30'h0, swrst_req, boot_isp}, 32'h2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule